// File: doc/BRIEF.md
# Self-Starting Frame Pulse Generator

This block produces a frame marker that is high for WIDTH-1 clocks and low for one, with a period of WIDTH clocks (eight by default). It uses no counter or decoder. A WIDTH-stage shift register feeds back on itself. Its lowest stage, bit 0, is the output. The level of that output picks the register's mode for the next clock. When the output is low, the mode is `MODE_LOAD`, and the register takes a fixed pattern: zero in the top stage and ones in every other stage. When the output is high, the mode is `MODE_SHIFT`, and every stage takes the value of the stage above it while a zero enters the top stage. After a load, a single zero walks down one stage per clock. It reaches the output WIDTH-1 clocks later, and that low output triggers the next load.

The block needs no initialization. Because zeros enter the top during shifts, any starting content gives a low output within WIDTH clocks. From that point the waveform is exact. The synchronous reset is optional: it places the value on `seed_i` into the register, so an arbitrary power-up state can be reproduced. If reset is tied low, the block still reaches the periodic waveform by itself.

There are two mode transitions. `MODE_SHIFT` to `MODE_LOAD` happens when the zero reaches the output. `MODE_LOAD` to `MODE_SHIFT` happens on the clock that performs the load.

Top module: `frame_sync_gen`

## Requirements
- R1: When `frame_o` is low with reset inactive, the next clock loads the fixed pattern. The pattern has stage WIDTH-1 = 0 and all lower stages = 1, so `frame_o` is high on the following cycle.
- R2: After the first low output, `frame_o` repeats exactly: one low cycle, then WIDTH-1 high cycles, with a period of WIDTH clocks.
- R3: From any register content, `frame_o` is low within WIDTH clocks. It is never high for more than WIDTH consecutive cycles.
- R4: While `rst_i` is high, each clock loads `seed_i` into the register. Bit i of `seed_i` goes to stage i. In the first cycle after reset is released, `frame_o` equals `seed_i[0]`.
- R5: Before the first low output, the register shifts and a zero enters the top stage. In cycle t after reset is released, `frame_o` therefore equals `seed_i[t]`, for as long as all earlier seed bits were 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Optional synchronous reset; loads `seed_i` |
| seed_i | input | WIDTH | Register content applied during reset |
| frame_o | output | 1 | Frame marker, low one cycle in WIDTH |

## Verification
The generator is started from every one of the 256 register contents for WIDTH = 8. Each start is released from reset and followed for three full periods. The expected level for each cycle comes from the count of trailing ones in the seed. This count separates three things: the seed bits passing straight to the output, the single clock on which the first low appears, and the steady waveform after it. A bad load pattern, a wrong serial input or a wrong mode choice changes at least one of these phases for some seed. Because the seeds follow one another without a gap, reset is also exercised while the generator is running.

// File: rtl/frame_sync_pkg.sv
package frame_sync_pkg;

    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } mode_e;

endpackage

// File: rtl/frame_sync_mode.sv
module frame_sync_mode
    import frame_sync_pkg::*;
(
    input  logic  out_bit_i,
    output mode_e mode_o
);

    always_comb begin
        unique case (out_bit_i)
            1'b0:    mode_o = MODE_LOAD;
            1'b1:    mode_o = MODE_SHIFT;
            default: mode_o = MODE_LOAD;
        endcase
    end

endmodule

// File: rtl/frame_sync_stage.sv
module frame_sync_stage
    import frame_sync_pkg::*;
#(
    parameter logic LOAD_BIT = 1'b1
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  seed_bit_i,
    input  mode_e mode_i,
    input  logic  shift_in_i,
    output logic  q_o
);

    logic q_r;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q_r <= seed_bit_i;
        end else begin
            unique case (mode_i)
                MODE_LOAD:  q_r <= LOAD_BIT;
                MODE_SHIFT: q_r <= shift_in_i;
                default:    q_r <= LOAD_BIT;
            endcase
        end
    end

    always_comb begin
        q_o = q_r;
    end

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
    import frame_sync_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic             frame_o
);

    localparam logic [WIDTH-1:0] LOAD_PAT = {1'b0, {(WIDTH-1){1'b1}}};
    localparam int               RUN_W    = $clog2(WIDTH + 1) + 1;

    logic [WIDTH-1:0] stage_q;
    mode_e            mode;

    frame_sync_mode u_mode (
        .out_bit_i (stage_q[0]),
        .mode_o    (mode)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic shift_in;
        if (i == WIDTH - 1) begin : g_top
            assign shift_in = 1'b0;
        end else begin : g_mid
            assign shift_in = stage_q[i+1];
        end
        frame_sync_stage #(
            .LOAD_BIT (LOAD_PAT[i])
        ) u_stage (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .seed_bit_i (seed_i[i]),
            .mode_i     (mode),
            .shift_in_i (shift_in),
            .q_o        (stage_q[i])
        );
    end

    assign frame_o = stage_q[0];

    // Observation state for the assertions
    logic [RUN_W-1:0] hi_run;
    logic             seen_low;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hi_run   <= '0;
            seen_low <= 1'b0;
        end else begin
            seen_low <= seen_low | ~frame_o;
            if (!frame_o)
                hi_run <= '0;
            else if (hi_run <= RUN_W'(WIDTH))
                hi_run <= hi_run + 1'b1;
        end
    end

    // R1: a low output is followed by a high one
    p_load_after_low_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        !frame_o |=> frame_o);

    // R2: steady period after the first low
    p_period_low_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_low && !frame_o) |-> (hi_run == RUN_W'(WIDTH - 1)));
    p_period_high_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (seen_low && hi_run < RUN_W'(WIDTH - 1)) |-> frame_o);

    // R3: high run never exceeds WIDTH
    p_high_run_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (hi_run == RUN_W'(WIDTH)) |-> !frame_o);

    // R4: released reset shows seed bit 0
    p_reset_seed_r4: assert property (@(posedge clk_i)
        ($past(rst_i) && !rst_i) |-> (frame_o == $past(seed_i[0])));

endmodule

// File: tb/frame_sync_gen_tb.sv
`timescale 1ns/1ps
module frame_sync_gen_tb;

    localparam int WIDTH  = 8;
    localparam int CYCLES = 3 * WIDTH;

    logic             clk = 1'b0;
    logic             rst_i;
    logic [WIDTH-1:0] seed_i;
    logic             frame_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    frame_sync_gen #(.WIDTH(WIDTH)) u_dut (
        .clk_i   (clk),
        .rst_i   (rst_i),
        .seed_i  (seed_i),
        .frame_o (frame_o)
    );

    task automatic check(input logic act, input logic exp, input string req,
                         input int seed, input int t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s seed=%0d cycle=%0d actual=%0b expected=%0b",
                     req, seed, t, act, exp);
        end
    endtask

    function automatic int trailing_ones(input logic [WIDTH-1:0] s);
        int n = 0;
        while (n < WIDTH && s[n]) n++;
        return n;
    endfunction

    initial begin
        rst_i  = 1'b1;
        seed_i = '0;
        repeat (2) @(negedge clk);
        // reset state: seed 0 gives a low output while held in reset (R4)
        check(frame_o, 1'b0, "R4", 0, -1);
        for (int s = 0; s < (1 << WIDTH); s++) begin
            int t0;
            @(negedge clk);
            rst_i  = 1'b1;
            seed_i = WIDTH'(s);
            @(negedge clk);
            rst_i  = 1'b0;
            t0 = trailing_ones(WIDTH'(s));
            for (int t = 0; t < CYCLES; t++) begin
                logic exp;
                string req;
                if (t < t0) begin
                    exp = 1'b1;
                    req = (t == 0) ? "R4" : "R5";
                end else begin
                    exp = ((t - t0) % WIDTH) != 0;
                    if (t == t0)                    req = (t == 0) ? "R4" : "R3";
                    else if (t == t0 + 1)           req = "R1";
                    else                            req = "R2";
                end
                check(frame_o, exp, req, s, t);
                @(negedge clk);
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule